// File: doc/BRIEF.md
# Protected System Clock Controller

This block produces the clock enables of a small microcontroller core. It takes the undivided main clock. From it, the block derives a CPU clock-enable strobe through a selectable divider and three peripheral enables at full rate, one eighth and one thirty-second of the main clock. It can also route one of the slower enables to a clock output pin. A byte-wide register bus reaches two control registers and a lock register. Both control registers only accept writes while the unlock bit in the lock register is set.

Software sets the divide ratio with a 2-bit field in the second control register, unless the fixed divide-by-8 bit in the first control register is set; that bit wins. A wait-gate bit chooses whether the peripheral enables keep running while the core sits in wait mode. Setting the stop bit halts every enable. Entering stop, like reset, restores divide-by-8 and high oscillator drive. An external wake input leaves stop, and the CPU strobe then restarts at one pulse in eight clocks.

Top module: `sysclk_ctrl`

## Requirements
- R1: After reset, address 0 reads 0x48, address 1 reads 0x20 and address 2 reads 0x00. div_ratio is 8, drive_high is 1 and stopped is 0.
- R2: A write to address 0 (control 0) or address 1 (control 1) changes nothing unless bit 0 of the lock register at address 2 is 1. Address 2 itself is always writable.
- R3: Fixed bits read back as follows, whatever was written. Control 0 bit 3 reads 1, and control 0 bits 4, 5 and 7 read 0. Control 1 bits 4:1 read 0. Lock bits 7:1 read 0. Address 3 reads 0.
- R4: When control 0 bit 6 is 1, div_ratio is 8. Otherwise control 1 bits 7:6 decide it: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 16.
- R5: Outside wait and stop, cpu_ce is a single-cycle pulse every div_ratio clocks. A new ratio starts only after the next pulse, so no interval is ever shorter than the old ratio.
- R6: Outside wait gating and stop, f1_en is high every cycle, f8_en once every 8 cycles and f32_en once every 32 cycles. Every f32_en pulse coincides with an f8_en pulse.
- R7: Control 0 bits 1:0 pick the clock output. 10 sends f8_en to clkout_pulse, and 11 sends f32_en. For 00 (port) and 01 (invalid), clkout_active and clkout_pulse stay 0.
- R8: While wait_mode is 1, cpu_ce is 0. If control 0 bit 2 is also 1, f1_en, f8_en and f32_en are 0. If that bit is 0, they keep running.
- R9: A permitted write of 1 to control 1 bit 0 enters stop. From then on stopped is 1 and every enable output is 0. The same write forces control 0 bit 6 and control 1 bit 5 to 1.
- R10: When wake is 1 while stopped, stopped clears at the next clock and control 1 bit 0 reads 0. The first cpu_ce comes on the eighth cycle after stop clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 control 0, 1 control 1, 2 lock) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register (combinational) |
| wait_mode | input | 1 | Core is in wait mode |
| wake | input | 1 | Wake request that ends stop mode |
| cpu_ce | output | 1 | CPU clock-enable strobe |
| f1_en | output | 1 | Full-rate peripheral enable |
| f8_en | output | 1 | Divide-by-8 peripheral enable |
| f32_en | output | 1 | Divide-by-32 peripheral enable |
| clkout_active | output | 1 | Output pin carries a clock rather than port data |
| clkout_pulse | output | 1 | Enable pulse routed to the output pin |
| div_ratio | output | 5 | Divide ratio currently selected by the registers |
| drive_high | output | 1 | Oscillator drive select (1 = high) |
| stopped | output | 1 | Stop mode is active |

## Verification
Some rules are checked on every cycle. These are the lock, the fixed read-back bits, the divide-by-8 override, the silence of every enable in stop, wait gating, the f32-within-f8 alignment, the idle clock output and the one-clock wake exit. Other behaviour needs whole sequences. These are the pulse spacing for each ratio, the absence of a short interval when the ratio changes, the exact count of each enable over a window, and the eighth-cycle restart after wake. Only the bench's directed and random scenarios can show these, against a register model kept in the bench.

// File: rtl/sysclk_pkg.sv
// sysclk_pkg: register addresses, reset images and the ratio decode shared
// by the clock controller, its sub-blocks and its checker.
package sysclk_pkg;
    localparam int RATIO_W = 5;
    localparam int DATA_W  = 8;

    localparam logic [1:0] A_CTRL0 = 2'd0;
    localparam logic [1:0] A_CTRL1 = 2'd1;
    localparam logic [1:0] A_LOCK  = 2'd2;

    // Writable bits and fixed-one bits of each control register
    localparam logic [DATA_W-1:0] C0_WMASK = 8'h47;
    localparam logic [DATA_W-1:0] C0_FIXED = 8'h08;
    localparam logic [DATA_W-1:0] C1_WMASK = 8'hE1;
    localparam logic [DATA_W-1:0] C0_RESET = 8'h48;
    localparam logic [DATA_W-1:0] C1_RESET = 8'h20;

    localparam int B_DIV8   = 6;
    localparam int B_WGATE  = 2;
    localparam int B_STOP   = 0;
    localparam int B_DRIVE  = 5;

    // Map the override bit and the 2-bit field onto a clock ratio
    function automatic logic [RATIO_W-1:0] ratio_decode(input logic div8,
                                                        input logic [1:0] sel);
        if (div8) return RATIO_W'(8);
        case (sel)
            2'b00:   return RATIO_W'(1);
            2'b01:   return RATIO_W'(2);
            2'b10:   return RATIO_W'(4);
            default: return RATIO_W'(16);
        endcase
    endfunction
endpackage

// File: rtl/sysclk_regs.sv
// sysclk_regs: two lock-protected control registers plus the lock register.
// Assumes one bus access per cycle; reads are combinational. Entering stop
// forces the divide-by-8 and high-drive bits; wake clears the stop bit.
module sysclk_regs
    import sysclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wake,
    output logic [DATA_W-1:0] ctrl0_q,
    output logic [DATA_W-1:0] ctrl1_q,
    output logic              prot_bit,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] c0_r, c1_r;
    logic              lock_r;
    logic              wr_c0, wr_c1;

    assign wr_c0 = we && lock_r && (addr == A_CTRL0);
    assign wr_c1 = we && lock_r && (addr == A_CTRL1);

    // Register update: protected writes, stop side effects, wake exit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c0_r   <= C0_RESET;
            c1_r   <= C1_RESET;
            lock_r <= 1'b0;
        end else begin
            if (we && addr == A_LOCK) lock_r <= wdata[0];
            if (wr_c0) c0_r <= (wdata & C0_WMASK) | C0_FIXED;
            if (wr_c1) begin
                c1_r <= wdata & C1_WMASK;
                if (wdata[B_STOP]) begin
                    c1_r[B_DRIVE] <= 1'b1;
                    c0_r[B_DIV8]  <= 1'b1;
                end
            end
            if (c1_r[B_STOP] && wake) c1_r[B_STOP] <= 1'b0;
        end
    end

    // Read multiplexer
    always_comb begin
        case (addr)
            A_CTRL0: rdata = c0_r;
            A_CTRL1: rdata = c1_r;
            A_LOCK:  rdata = {{(DATA_W-1){1'b0}}, lock_r};
            default: rdata = '0;
        endcase
    end

    assign ctrl0_q  = c0_r;
    assign ctrl1_q  = c1_r;
    assign prot_bit = lock_r;
endmodule

// File: rtl/sysclk_cpu_div.sv
// sysclk_cpu_div: free-running divider issuing one enable pulse every
// 'ratio' clocks. A new ratio is latched only at terminal count. While
// halted the count is held at zero and the ratio keeps reloading.
module sysclk_cpu_div #(
    parameter int RATIO_W      = sysclk_pkg::RATIO_W,
    parameter int RESUME_RATIO = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [RATIO_W-1:0] ratio,
    output logic               ce
);
    logic [RATIO_W-1:0] cnt, cur;
    logic               term;

    assign term = (cnt == cur - RATIO_W'(1));
    assign ce   = run && term;

    // Count and reload the active ratio at terminal count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            cur <= RATIO_W'(RESUME_RATIO);
        end else if (!run) begin
            cnt <= '0;
            cur <= ratio;
        end else if (term) begin
            cnt <= '0;
            cur <= ratio;
        end else begin
            cnt <= cnt + RATIO_W'(1);
        end
    end
endmodule

// File: rtl/sysclk_prescale.sv
// sysclk_prescale: one binary prescaler on the main clock producing the
// full-rate, mid and slow peripheral enables. Slow pulses always coincide
// with mid pulses. Assumes MID_LOG < SLOW_LOG.
module sysclk_prescale #(
    parameter int MID_LOG  = 3,
    parameter int SLOW_LOG = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic gate,
    output logic f_full,
    output logic f_mid,
    output logic f_slow
);
    logic [SLOW_LOG-1:0] pre;
    logic                live;

    assign live = run && !gate;

    // Prescaler advances whenever the clock tree runs
    always_ff @(posedge clk) begin
        if (!rst_n || !run) pre <= '0;
        else                pre <= pre + SLOW_LOG'(1);
    end

    assign f_full = live;
    assign f_mid  = live && (&pre[MID_LOG-1:0]);
    assign f_slow = live && (&pre);
endmodule

// File: rtl/sysclk_ctrl.sv
// sysclk_ctrl: top of the protected clock controller. Ties the registers
// to the CPU divider, the peripheral prescaler and the clock output mux.
// Assumes wait_mode and wake are synchronous to clk.
module sysclk_ctrl
    import sysclk_pkg::*;
#(
    parameter int MID_LOG  = 3,
    parameter int SLOW_LOG = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic [1:0]         bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic               wait_mode,
    input  logic               wake,
    output logic               cpu_ce,
    output logic               f1_en,
    output logic               f8_en,
    output logic               f32_en,
    output logic               clkout_active,
    output logic               clkout_pulse,
    output logic [RATIO_W-1:0] div_ratio,
    output logic               drive_high,
    output logic               stopped
);
    logic [DATA_W-1:0] ctrl0_q, ctrl1_q;
    logic              prot_bit;
    logic              run, ce_raw, wgate;

    sysclk_regs u_regs (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
        .wdata(bus_wdata), .wake(wake), .ctrl0_q(ctrl0_q),
        .ctrl1_q(ctrl1_q), .prot_bit(prot_bit), .rdata(bus_rdata)
    );

    assign stopped    = ctrl1_q[B_STOP];
    assign run        = !stopped;
    assign drive_high = ctrl1_q[B_DRIVE];
    assign div_ratio  = ratio_decode(ctrl0_q[B_DIV8], ctrl1_q[7:6]);
    assign wgate      = wait_mode && ctrl0_q[B_WGATE];

    sysclk_cpu_div #(.RATIO_W(RATIO_W), .RESUME_RATIO(8)) u_div (
        .clk(clk), .rst_n(rst_n), .run(run), .ratio(div_ratio), .ce(ce_raw)
    );

    assign cpu_ce = ce_raw && !wait_mode;

    sysclk_prescale #(.MID_LOG(MID_LOG), .SLOW_LOG(SLOW_LOG)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run), .gate(wgate),
        .f_full(f1_en), .f_mid(f8_en), .f_slow(f32_en)
    );

    // Clock output pin selection: bit 1 enables, bit 0 picks the slow tap
    always_comb begin
        clkout_active = ctrl0_q[1];
        clkout_pulse  = ctrl0_q[1] && (ctrl0_q[0] ? f32_en : f8_en);
    end
endmodule

// File: rtl/sysclk_ctrl_chk.sv
// sysclk_ctrl_chk: cycle-level properties of the clock controller, bound
// to every instance of sysclk_ctrl.
module sysclk_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] bus_addr,
    input logic [7:0] bus_rdata,
    input logic       wait_mode,
    input logic       wake,
    input logic       cpu_ce,
    input logic       f1_en,
    input logic       f8_en,
    input logic       f32_en,
    input logic       clkout_active,
    input logic       clkout_pulse,
    input logic [4:0] div_ratio,
    input logic       stopped,
    input logic       prot_bit,
    input logic [7:0] ctrl0_q,
    input logic [7:0] ctrl1_q
);
    AST_LOCKED_C0: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_bit |=> $stable(ctrl0_q)); // R2
    AST_LOCKED_C1: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_bit |=> $stable(ctrl1_q[7:1])); // R2
    AST_RESV_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd0) |-> (bus_rdata[3] && bus_rdata[5:4] == 2'b00 && !bus_rdata[7])); // R3
    AST_DIV8_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl0_q[6] |-> (div_ratio == 5'd8)); // R4
    AST_F32_IN_F8: assert property (@(posedge clk) disable iff (!rst_n)
        f32_en |-> f8_en); // R6
    AST_PIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !clkout_active |-> !clkout_pulse); // R7
    AST_WAIT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_mode && ctrl0_q[2]) |-> !(f1_en || f8_en || f32_en || cpu_ce)); // R8
    AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        stopped |-> !(cpu_ce || f1_en || f8_en || f32_en || clkout_pulse)); // R9
    AST_WAKE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped && wake) |=> !stopped); // R10
endmodule

bind sysclk_ctrl sysclk_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .wait_mode(wait_mode), .wake(wake), .cpu_ce(cpu_ce), .f1_en(f1_en),
    .f8_en(f8_en), .f32_en(f32_en), .clkout_active(clkout_active),
    .clkout_pulse(clkout_pulse), .div_ratio(div_ratio), .stopped(stopped),
    .prot_bit(prot_bit), .ctrl0_q(ctrl0_q), .ctrl1_q(ctrl1_q)
);

// File: tb/sysclk_ctrl_test.sv
module sysclk_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       wait_mode = 1'b0;
    logic       wake = 1'b0;
    logic       cpu_ce, f1_en, f8_en, f32_en, clkout_active, clkout_pulse;
    logic [4:0] div_ratio;
    logic       drive_high, stopped;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int last_ce = 0;
    int gap = 0;
    int ce_seen = 0;
    logic [7:0] m0 = 8'h48, m1 = 8'h20;
    logic       mp = 1'b0;

    always #5 clk = ~clk;

    sysclk_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wait_mode(wait_mode),
        .wake(wake), .cpu_ce(cpu_ce), .f1_en(f1_en), .f8_en(f8_en),
        .f32_en(f32_en), .clkout_active(clkout_active),
        .clkout_pulse(clkout_pulse), .div_ratio(div_ratio),
        .drive_high(drive_high), .stopped(stopped)
    );

    // CPU strobe spacing monitor
    always @(negedge clk) begin
        cyc++;
        if (cpu_ce) begin
            gap = cyc - last_ce;
            last_ce = cyc;
            ce_seen++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_ratio(input logic [7:0] c0, input logic [7:0] c1);
        if (c0[6]) return 8;
        case (c1[7:6])
            2'b00: return 1;
            2'b01: return 2;
            2'b10: return 4;
            default: return 16;
        endcase
    endfunction

    task automatic model_wr(input logic [1:0] a, input logic [7:0] d);
        if (a == 2'd2) mp = d[0];
        else if (mp && a == 2'd0) m0 = {1'b0, d[6], 2'b00, 1'b1, d[2:0]};
        else if (mp && a == 2'd1) begin
            m1 = {d[7:5], 4'b0000, d[0]};
            if (d[0]) begin m1[5] = 1'b1; m0[6] = 1'b1; end
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        model_wr(a, d);
        #1;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic check_regs(input string req);
        logic [7:0] v;
        rd(2'd0, v); check(v == m0, req, v, m0);
        rd(2'd1, v); check(v == m1, req, v, m1);
        rd(2'd2, v); check(v == {7'd0, mp}, req, v, {7'd0, mp});
        rd(2'd3, v); check(v == 8'h00, req, v, 0);
        check(int'(div_ratio) == exp_ratio(m0, m1), req, div_ratio, exp_ratio(m0, m1));
        check(drive_high == m1[5], req, drive_high, m1[5]);
        check(stopped == m1[0], req, stopped, m1[0]);
    endtask

    task automatic wait_ce();
        int n = ce_seen;
        while (ce_seen == n) begin @(negedge clk); #1; end
    endtask

    // Count enables over a 64-cycle window
    task automatic count64(output int c1, output int c8, output int c32,
                           output int cce, output int cpin, output int bad);
        c1 = 0; c8 = 0; c32 = 0; cce = 0; cpin = 0; bad = 0;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk); #1;
            c1 += int'(f1_en); c8 += int'(f8_en); c32 += int'(f32_en);
            cce += int'(cpu_ce); cpin += int'(clkout_pulse);
            if (f32_en && !f8_en) bad++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int c1, c8, c32, cce, cpin, bad, t0;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset image
        check_regs("R1");

        // R2 writes ignored while locked
        wr(2'd0, 8'hFF); wr(2'd1, 8'hC0);
        rd(2'd0, v); check(v == 8'h48, "R2", v, 8'h48);
        rd(2'd1, v); check(v == 8'h20, "R2", v, 8'h20);
        check(div_ratio == 5'd8, "R2", div_ratio, 8);

        // R3 fixed bits
        wr(2'd2, 8'hFF);
        rd(2'd2, v); check(v == 8'h01, "R3", v, 1);
        wr(2'd0, 8'h37);
        rd(2'd0, v); check(v == 8'h0F, "R3", v, 8'h0F);
        wr(2'd1, 8'h1E);
        rd(2'd1, v); check(v == 8'h00, "R3", v, 0);
        wr(2'd0, 8'h00);

        // R4 R5 ratio sweep
        for (int s = 0; s < 4; s++) begin
            wr(2'd1, 8'(s << 6));
            check(int'(div_ratio) == exp_ratio(m0, m1), "R4", div_ratio, exp_ratio(m0, m1));
            wait_ce(); wait_ce(); wait_ce();
            check(gap == exp_ratio(m0, m1), "R5", gap, exp_ratio(m0, m1));
        end
        wr(2'd0, 8'h40);
        check(div_ratio == 5'd8, "R4", div_ratio, 8);
        wait_ce(); wait_ce(); wait_ce();
        check(gap == 8, "R5", gap, 8);

        // R5 ratio change waits for terminal count: 16 then 1
        wr(2'd0, 8'h00); wr(2'd1, 8'hC0);
        wait_ce(); wait_ce();
        wr(2'd1, 8'h00);
        wait_ce(); check(gap == 16, "R5", gap, 16);
        wait_ce(); check(gap == 1, "R5", gap, 1);

        // R6 peripheral enables
        wr(2'd0, 8'h40);
        count64(c1, c8, c32, cce, cpin, bad);
        check(c1 == 64, "R6", c1, 64);
        check(c8 == 8, "R6", c8, 8);
        check(c32 == 2, "R6", c32, 2);
        check(bad == 0, "R6", bad, 0);

        // R7 clock output modes
        for (int m = 0; m < 4; m++) begin
            wr(2'd0, 8'(8'h40 | m));
            count64(c1, c8, c32, cce, cpin, bad);
            check(clkout_active == (m >= 2), "R7", clkout_active, m >= 2);
            check(cpin == (m == 2 ? 8 : (m == 3 ? 2 : 0)), "R7", cpin,
                  (m == 2 ? 8 : (m == 3 ? 2 : 0)));
        end

        // R8 wait gating
        wr(2'd0, 8'h44);
        wait_mode = 1'b1;
        count64(c1, c8, c32, cce, cpin, bad);
        check(c1 + c8 + c32 == 0, "R8", c1 + c8 + c32, 0);
        check(cce == 0, "R8", cce, 0);
        wait_mode = 1'b0;
        wr(2'd0, 8'h40);
        wait_mode = 1'b1;
        count64(c1, c8, c32, cce, cpin, bad);
        check(c1 == 64 && c8 == 8 && c32 == 2, "R8", c1, 64);
        check(cce == 0, "R8", cce, 0);
        wait_mode = 1'b0;

        // R9 stop entry
        wr(2'd0, 8'h02); wr(2'd1, 8'h40);
        wr(2'd1, 8'h01);
        rd(2'd0, v); check(v == 8'h4A, "R9", v, 8'h4A);
        rd(2'd1, v); check(v == 8'h21, "R9", v, 8'h21);
        check(stopped == 1'b1, "R9", stopped, 1);
        count64(c1, c8, c32, cce, cpin, bad);
        check(c1 + c8 + c32 + cce + cpin == 0, "R9", c1 + c8 + c32 + cce + cpin, 0);

        // R10 wake
        @(negedge clk); wake = 1'b1;
        @(negedge clk); wake = 1'b0;
        #1;
        t0 = cyc;
        check(stopped == 1'b0, "R10", stopped, 0);
        m1[0] = 1'b0;
        rd(2'd1, v); check(v == 8'h20, "R10", v, 8'h20);
        wait_ce();
        check(last_ce - t0 == 7, "R10", last_ce - t0 + 1, 8);

        // Random register traffic against the model
        for (int i = 0; i < 300; i++) begin
            logic [1:0] a;
            logic [7:0] d;
            a = 2'($urandom_range(0, 3));
            d = 8'($urandom);
            if (a == 2'd1) d[0] = 1'b0;
            if (a == 2'd2 && ($urandom_range(0, 3) != 0)) d[0] = 1'b1;
            wr(a, d);
            check_regs((a == 2'd2 || !mp) ? "R2" : "R4");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule